// File: doc/BRIEF.md
# Firmware Hub Quad-Byte Write Target

This block sits on the memory side of a 4-bit multiplexed firmware hub bus and decodes one four-byte program cycle. It watches an active-low frame strobe and the incoming nibble lane, recognises the start code, and compares the following ID nibble with its own 4-bit strap inputs. It then collects a 28-bit address, most significant nibble first, and checks the size nibble. It gathers eight data nibbles, least significant nibble of each byte first. It waits out the host turnaround and answers with a one-cycle completion sync. Finally it drives one all-ones turnaround cycle and releases the lane.

The shared tri-state lane is split at the port boundary into an input copy, an output value and an output enable, so the pad ring builds the actual bidirectional pin. When the cycle completes, a single-cycle write request presents the 4-byte-aligned address and a 32-bit little-endian data word to the array controller. A start code seen with the strobe low at any point restarts decoding and drops whatever partial cycle was in progress.

Top module: `fwh_qwrite_target`

## Requirements
- R1: A cycle begins only at a rising edge where `frame_n` is 0 and `bus_in` is 4'b1110. Any other start nibble, or 4'b1110 with `frame_n` high, leaves the block idle, and it neither drives the lane nor issues a request.
- R2: The nibble in clock 2 is compared with `id_strap`. On a mismatch the block drops the cycle, never drives the lane and issues no request.
- R3: Clocks 3 to 9 carry the address, most significant nibble first. `wr_addr` is that 28-bit value with bits [1:0] forced to 0.
- R4: The nibble in clock 10 must be 4'b0010. Any other value makes the block return to idle, and it neither drives the lane nor issues a request.
- R5: Clocks 11 to 18 carry data as four bytes in byte-offset order 0,1,2,3, each byte low nibble first. The byte at offset k appears in `wr_data[8k+7:8k]`.
- R6: `bus_oe` stays 0 through the host turnaround (clock 19) and the handover clock (clock 20).
- R7: In clock 21 the block drives `bus_out` = 4'b0000 with `bus_oe` = 1, and `wr_valid` is 1 for exactly that one clock with the address and data of the cycle.
- R8: In clock 22 the block drives 4'b1111 with `bus_oe` = 1. In clock 23 `bus_oe` is 0, and a new start may follow in clock 24.
- R9: A start code with `frame_n` low, seen in any state, restarts decoding at the ID nibble. The partial cycle produces no request.
- R10: While `rst_n` is 0 and after its release, `bus_oe` and `wr_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_in | input | 4 | Nibble currently on the shared lane |
| id_strap | input | 4 | Strapped identity of this target |
| bus_out | output | 4 | Nibble the target drives when enabled |
| bus_oe | output | 1 | Output enable of the lane drivers |
| wr_valid | output | 1 | One-clock write request strobe |
| wr_addr | output | 28 | Aligned write address |
| wr_data | output | 32 | Write data, byte offset 0 in bits 7:0 |

## Verification
The bench builds the block with its default 28-bit address and four-byte data path. With these values a whole framed cycle is only 23 clocks, which makes exhaustive sweeps cheap. Every ID nibble is swept against a fixed strap, every strap value against a matching ID, and all sixteen size codes. The bench also replays address and data patterns generated arithmetically, with nonzero low address bits. Mid-address and mid-data restarts are also within reach, and each clock of the turnaround and sync handshake is compared against its expected enable and nibble.

// File: rtl/fwh_qw_pkg.sv
package fwh_qw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ADDR,
        ST_SIZE,
        ST_DATA,
        ST_HOST_TAR,
        ST_HANDOVER,
        ST_SYNC,
        ST_DRIVE_ONES,
        ST_RELEASE
    } fsm_e;

    localparam logic [3:0] START_CODE = 4'b1110;
    localparam logic [3:0] SIZE_QUAD  = 4'b0010;
    localparam logic [3:0] NIB_ONES   = 4'b1111;
    localparam logic [3:0] SYNC_DONE  = 4'b0000;

endpackage

// File: rtl/fwh_addr_shift.sv
// Collects the address most significant nibble first.
module fwh_addr_shift #(
    parameter int ADDR_W = 28,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [NIB_W-1:0]  nib,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (shift_en) begin
            addr_d = {addr_q[ADDR_W-NIB_W-1:0], nib};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/fwh_data_gather.sv
// Places each arriving data nibble in its slot. Bytes come in offset order,
// low nibble first, so slot j lands at bits [4j+3:4j] of the word.
module fwh_data_gather #(
    parameter int DATA_BYTES = 4,
    parameter int IDX_W      = 3,
    localparam int NIB_COUNT = DATA_BYTES * 2,
    localparam int DATA_W    = DATA_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [3:0]        nib,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] data_d, data_q;

    for (genvar j = 0; j < NIB_COUNT; j++) begin : g_slot
        always_comb begin
            data_d[4*j +: 4] = data_q[4*j +: 4];
            if (load_en && idx == IDX_W'(j)) begin
                data_d[4*j +: 4] = nib;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign data = data_q;
endmodule

// File: rtl/fwh_qwrite_target.sv
module fwh_qwrite_target
    import fwh_qw_pkg::*;
#(
    parameter int ADDR_W     = 28,
    parameter int DATA_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_n,
    input  logic [3:0]              bus_in,
    input  logic [3:0]              id_strap,
    output logic [3:0]              bus_out,
    output logic                    bus_oe,
    output logic                    wr_valid,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [DATA_BYTES*8-1:0] wr_data
);
    localparam int ADDR_NIBS = ADDR_W / 4;
    localparam int DATA_NIBS = DATA_BYTES * 2;
    localparam int MAX_NIBS  = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
    localparam int CNT_W     = (MAX_NIBS > 1) ? $clog2(MAX_NIBS) : 1;

    typedef struct packed {
        fsm_e             st;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic shift_en, load_en, start_seen;
    logic [ADDR_W-1:0] addr_raw;

    always_comb begin
        ctl_d      = ctl_q;
        shift_en   = 1'b0;
        load_en    = 1'b0;
        start_seen = !frame_n && (bus_in == START_CODE);

        case (ctl_q.st)
            ST_IDLE: ;
            ST_ID: begin
                ctl_d.cnt = '0;
                ctl_d.st  = (bus_in == id_strap) ? ST_ADDR : ST_IDLE;
            end
            ST_ADDR: begin
                shift_en = 1'b1;
                if (ctl_q.cnt == CNT_W'(ADDR_NIBS - 1)) begin
                    ctl_d.cnt = '0;
                    ctl_d.st  = ST_SIZE;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_SIZE: begin
                ctl_d.cnt = '0;
                ctl_d.st  = (bus_in == SIZE_QUAD) ? ST_DATA : ST_IDLE;
            end
            ST_DATA: begin
                load_en = 1'b1;
                if (ctl_q.cnt == CNT_W'(DATA_NIBS - 1)) begin
                    ctl_d.cnt = '0;
                    ctl_d.st  = ST_HOST_TAR;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_HOST_TAR:   ctl_d.st = ST_HANDOVER;
            ST_HANDOVER:   ctl_d.st = ST_SYNC;
            ST_SYNC:       ctl_d.st = ST_DRIVE_ONES;
            ST_DRIVE_ONES: ctl_d.st = ST_RELEASE;
            ST_RELEASE:    ctl_d.st = ST_IDLE;
            default:       ctl_d.st = ST_IDLE;
        endcase

        // A fresh start always wins and discards any partial cycle.
        if (start_seen) begin
            ctl_d.st  = ST_ID;
            ctl_d.cnt = '0;
            shift_en  = 1'b0;
            load_en   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cnt: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    fwh_addr_shift #(
        .ADDR_W (ADDR_W),
        .NIB_W  (4)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .nib      (bus_in),
        .addr     (addr_raw)
    );

    fwh_data_gather #(
        .DATA_BYTES (DATA_BYTES),
        .IDX_W      (CNT_W)
    ) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .idx     (ctl_q.cnt),
        .nib     (bus_in),
        .data    (wr_data)
    );

    // Moore outputs straight from the state register.
    assign bus_oe   = (ctl_q.st == ST_SYNC) || (ctl_q.st == ST_DRIVE_ONES);
    assign bus_out  = (ctl_q.st == ST_SYNC) ? SYNC_DONE : NIB_ONES;
    assign wr_valid = (ctl_q.st == ST_SYNC);
    assign wr_addr  = {addr_raw[ADDR_W-1:2], 2'b00};
endmodule

// File: rtl/fwh_qw_checker.sv
module fwh_qw_checker
    import fwh_qw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic [3:0] bus_in,
    input logic [3:0] bus_out,
    input logic       bus_oe,
    input logic       wr_valid,
    input logic [1:0] wr_addr_lo
);
    // R7: the request coincides with the driven sync nibble
    assert_sync_with_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (bus_oe && bus_out == SYNC_DONE));

    // R7: request lasts a single clock
    assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R8: all-ones turnaround follows the sync
    assert_ones_after_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (bus_oe && bus_out == NIB_ONES));

    // R8: the lane is released after the all-ones clock
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && bus_out == NIB_ONES) |=> !bus_oe);

    // R6: the target only starts driving in the sync clock
    assert_drive_starts_at_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> wr_valid);

    // R3: the request address is 4-byte aligned
    assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr_lo == 2'b00));

    // R9: a start code aborts, so the next clock neither drives nor requests
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && bus_in == START_CODE) |=> (!bus_oe && !wr_valid));
endmodule

bind fwh_qwrite_target fwh_qw_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .bus_in     (bus_in),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .wr_valid   (wr_valid),
    .wr_addr_lo (wr_addr[1:0])
);

// File: tb/fwh_qwrite_target_tb.sv
module fwh_qwrite_target_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [3:0]  bus_in = 4'hF;
    logic [3:0]  strap = 4'h5;
    logic [3:0]  bus_out;
    logic        bus_oe;
    logic        wr_valid;
    logic [27:0] wr_addr;
    logic [31:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fwh_qwrite_target u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .bus_in   (bus_in),
        .id_strap (strap),
        .bus_out  (bus_out),
        .bus_oe   (bus_oe),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // Host nibble for clock c of a framed write.
    function automatic logic [3:0] host_nib(input int c, input logic [3:0] sc,
        input logic [3:0] id, input logic [3:0] size, input logic [27:0] addr,
        input logic [31:0] data);
        if (c == 1) return sc;
        if (c == 2) return id;
        if (c >= 3 && c <= 9) return addr[(9 - c) * 4 +: 4];
        if (c == 10) return size;
        if (c >= 11 && c <= 18) return data[(c - 11) * 4 +: 4];
        return 4'hF;
    endfunction

    // One 23-clock framed write; outputs of clock c are sampled at the
    // falling edge that opens clock c, before its input is driven.
    task automatic write_cycle(input bit fr_low, input logic [3:0] sc,
        input logic [3:0] id, input logic [3:0] size, input logic [27:0] addr,
        input logic [31:0] data, input bit ok, input string tag);
        bit hs_ok = 1'b1;
        int vcnt = 0;
        int vcyc = 0;
        logic [27:0] ga = '0;
        logic [31:0] gd = '0;
        for (int c = 1; c <= 23; c++) begin
            @(negedge clk);
            if (bus_oe !== (ok && (c == 21 || c == 22))) hs_ok = 1'b0;
            if (ok && c == 21 && bus_out !== 4'h0) hs_ok = 1'b0;
            if (ok && c == 22 && bus_out !== 4'hF) hs_ok = 1'b0;
            if (wr_valid === 1'b1) begin
                vcnt++;
                vcyc = c;
                ga = wr_addr;
                gd = wr_data;
            end
            frame_n = (c == 1) ? !fr_low : 1'b1;
            bus_in  = host_nib(c, sc, id, size, addr, data);
        end
        check(hs_ok, {tag, " R6/R8 lane enable and nibble per clock"}, 64'(hs_ok), 64'd1);
        check(vcnt == (ok ? 1 : 0), {tag, " request count"}, 64'(vcnt), ok ? 64'd1 : 64'd0);
        if (ok) begin
            check(vcyc == 21, "R7 request clock", 64'(vcyc), 64'd21);
            check(ga == {addr[27:2], 2'b00}, "R3 aligned address", 64'(ga),
                  64'({addr[27:2], 2'b00}));
            check(gd == data, "R5 data byte order", 64'(gd), 64'(data));
        end
    endtask

    // Drive the first n clocks of a write, then abandon it.
    task automatic partial(input int n);
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            frame_n = (c == 1) ? 1'b0 : 1'b1;
            bus_in  = host_nib(c, 4'b1110, strap, 4'b0010, 28'hAAAAAAA, 32'h55555555);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=1 exp=0");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(bus_oe === 1'b0 && wr_valid === 1'b0, "R10 in reset", {bus_oe, wr_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_oe === 1'b0 && wr_valid === 1'b0, "R10 after reset", {bus_oe, wr_valid}, 0);

        // R2: every ID against a fixed strap
        strap = 4'h5;
        for (int i = 0; i < 16; i++) begin
            write_cycle(1'b1, 4'b1110, 4'(i), 4'b0010, 28'h1234567, 32'hCAFEF00D,
                        i == 5, "R2 id sweep");
        end
        // R2: every strap value with a matching ID
        for (int s = 0; s < 16; s++) begin
            strap = 4'(s);
            write_cycle(1'b1, 4'b1110, 4'(s), 4'b0010, 28'(s * 28'h0111111),
                        32'(s * 32'h01020304), 1'b1, "R2 strap sweep");
        end
        strap = 4'h9;
        // R4: all size codes
        for (int z = 0; z < 16; z++) begin
            write_cycle(1'b1, 4'b1110, 4'h9, 4'(z), 28'h0FEDCBA, 32'h89ABCDEF,
                        z == 2, "R4 size sweep");
        end
        // R3/R5: arithmetic address and data patterns
        for (int i = 0; i < 8; i++) begin
            logic [31:0] a32;
            a32 = (32'(i) * 32'h01234567) ^ 32'h0ABCDEF3;
            write_cycle(1'b1, 4'b1110, 4'h9, 4'b0010, a32[27:0],
                        32'h9E3779B9 * 32'(i + 1), 1'b1, "R3 R5 pattern");
        end
        // R1: wrong start codes or strobe high
        write_cycle(1'b0, 4'b1110, 4'h9, 4'b0010, 28'h1111111, 32'h1, 1'b0, "R1 strobe high");
        write_cycle(1'b1, 4'b1101, 4'h9, 4'b0010, 28'h2222222, 32'h2, 1'b0, "R1 code D");
        write_cycle(1'b1, 4'b0000, 4'h9, 4'b0010, 28'h3333333, 32'h3, 1'b0, "R1 code 0");
        write_cycle(1'b1, 4'b1111, 4'h9, 4'b0010, 28'h4444444, 32'h4, 1'b0, "R1 code F");
        // R9: restart in the address phase and in the data phase
        partial(5);
        write_cycle(1'b1, 4'b1110, 4'h9, 4'b0010, 28'h7654321, 32'h0BADBEEF, 1'b1,
                    "R9 restart in address");
        partial(14);
        write_cycle(1'b1, 4'b1110, 4'h9, 4'b0010, 28'h00000FF, 32'h13579BDF, 1'b1,
                    "R9 restart in data");
        // R8: back-to-back cycles, the previous one ends with the lane released
        write_cycle(1'b1, 4'b1110, 4'h9, 4'b0010, 28'hFFFFFFF, 32'hFFFFFFFF, 1'b1,
                    "R8 back to back");
        @(negedge clk);
        check(bus_oe === 1'b0 && wr_valid === 1'b0, "R8 idle after cycle",
              {bus_oe, wr_valid}, 0);
        finish_run();
    end
endmodule